// File: doc/BRIEF.md
# Selectable Word Rearrangement Unit

This block sits next to a processor's ALU. It takes one 32-bit operand and returns a rearranged copy of it. An 8-bit operation selector picks the rearrangement: the whole word mirrored bit by bit, the four bytes put in the opposite order, or the two 16-bit halves traded places. Any selector code without an operation assigned returns the operand unchanged. All three rearrangements are computed in parallel, and a multiplexer driven by the selector chooses which one reaches the output.

The default build registers the result behind a start/done handshake. The processor raises `start` for one cycle and holds the operand and selector steady while it does. On the next edge `done` rises and the chosen value appears on `result`, where it stays until the next start. Every edge is qualified by `clk_en`, and a synchronous reset clears the output. Setting `REGISTERED` to 0 gives the single-cycle form instead: `result` follows the inputs combinationally and `done` simply mirrors `start`.

Top module: `word_swap_unit`

## Requirements
- R1: With selector code 0, the result is the operand with bit i moved to bit 31-i for every i.
- R2: With selector code 1, the result is the operand with its bytes in the opposite order: bits 7:0 go to 31:24, 15:8 go to 23:16, 23:16 go to 15:8 and 31:24 go to 7:0.
- R3: With selector code 2, the result is the operand with bits 31:16 and bits 15:0 exchanged.
- R4: With any selector code from 3 to 255, the result equals the operand unchanged.
- R5: In the registered build, an edge that sees `start` high with `clk_en` high makes `done` high and shows the new result after that same edge. Starts on consecutive edges give one result per cycle.
- R6: In the registered build, an enabled edge with `start` low drives `done` low and leaves `result` unchanged.
- R7: An edge with `clk_en` low changes neither `result` nor `done`, even when `start` is high.
- R8: An edge with `rst` high sets `result` to zero and `done` low, whatever the value of `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Qualifies every clock edge |
| start | input | 1 | One-cycle request that captures the operand and selector |
| sel | input | 8 | Operation selector |
| operand | input | 32 | Word to rearrange |
| result | output | 32 | Rearranged word |
| done | output | 1 | High for the cycle after an accepted start |

## Verification
The assertions assume that `operand` and `sel` are valid on every edge where `start` and `clk_en` are both high. They compare the result against the values those two inputs had one edge earlier. The stimulus changes inputs only on the falling edge. It fills both inputs at the moment it raises `start`, including the start that is held through a stalled edge. It drives reset only between requests, so no request is cut short by reset.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [7:0] {
    WS_OP_MIRROR = 8'd0,
    WS_OP_BYTES  = 8'd1,
    WS_OP_HALVES = 8'd2
  } ws_op_e;
endpackage

// File: rtl/ws_permute.sv
module ws_permute #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mirror_o,
  output logic [DATA_W-1:0] bytes_o,
  output logic [DATA_W-1:0] halves_o
);
  localparam int NBYTES = DATA_W / 8;
  localparam int HALF   = DATA_W / 2;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign mirror_o[i] = din[DATA_W-1-i];
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
    assign bytes_o[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
  end

  assign halves_o = {din[HALF-1:0], din[DATA_W-1:HALF]};
endmodule

// File: rtl/ws_select.sv
module ws_select #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 8
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] mirror_i,
  input  logic [DATA_W-1:0] bytes_i,
  input  logic [DATA_W-1:0] halves_i,
  output logic [DATA_W-1:0] dout
);
  import ws_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_W'(WS_OP_MIRROR): dout = mirror_i;
      SEL_W'(WS_OP_BYTES):  dout = bytes_i;
      SEL_W'(WS_OP_HALVES): dout = halves_i;
      default:              dout = din;
    endcase
  end
endmodule

// File: rtl/ws_stage.sv
module ws_stage #(
  parameter int DATA_W     = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              clk_en,
  input  logic              start,
  input  logic [DATA_W-1:0] next_val,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  if (REGISTERED) begin : g_reg
    logic [DATA_W-1:0] res_q;
    logic              done_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q  <= '0;
        done_q <= 1'b0;
      end else if (clk_en) begin
        done_q <= start;
        if (fire) res_q <= next_val;
      end
    end
    assign result = res_q;
    assign done   = done_q;
  end else begin : g_comb
    assign result = next_val;
    assign done   = start;
  end
endmodule

// File: rtl/word_swap_unit.sv
module word_swap_unit #(
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic [DATA_W-1:0] mirror_w, bytes_w, halves_w, chosen_w;
  logic              fire;

  assign fire = clk_en & start;

  ws_permute #(.DATA_W(DATA_W)) u_perm (
    .din(operand), .mirror_o(mirror_w), .bytes_o(bytes_w), .halves_o(halves_w)
  );

  ws_select #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel (
    .sel(sel), .din(operand), .mirror_i(mirror_w), .bytes_i(bytes_w),
    .halves_i(halves_w), .dout(chosen_w)
  );

  ws_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_stage (
    .clk(clk), .rst(rst), .fire(fire), .clk_en(clk_en), .start(start),
    .next_val(chosen_w), .result(result), .done(done)
  );
endmodule

// File: rtl/ws_chk.sv
module ws_chk #(
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              start,
  input logic              fire,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] result,
  input logic              done
);
  if (REGISTERED) begin : g_chk
    AST_MIRROR: assert property (@(posedge clk) disable iff (rst)
      fire && sel == 0 |=> result == {<<{$past(operand)}}); // R1
    AST_BYTES: assert property (@(posedge clk) disable iff (rst)
      fire && sel == 1 |=> result == {<<8{$past(operand)}}); // R2
    AST_HALVES: assert property (@(posedge clk) disable iff (rst)
      fire && sel == 2 |=> result == {<<16{$past(operand)}}); // R3
    AST_PASS: assert property (@(posedge clk) disable iff (rst)
      fire && sel > 2 |=> result == $past(operand)); // R4
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
      fire |=> done); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      clk_en && !start |=> !done && $stable(result)); // R6
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
      !clk_en |=> $stable(result) && $stable(done)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> result == '0 && !done); // R8
  end
endmodule

bind word_swap_unit ws_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .REGISTERED(REGISTERED)) chk_i (
  .clk(clk), .rst(rst), .clk_en(clk_en), .start(start), .fire(fire),
  .sel(sel), .operand(operand), .result(result), .done(done)
);

// File: tb/word_swap_unit_tb_top.sv
module word_swap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, clk_en, start;
  logic [7:0]  sel;
  logic [31:0] operand, result;
  logic        done;
  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  word_swap_unit dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .start(start), .sel(sel),
    .operand(operand), .result(result), .done(done)
  );

  function automatic logic [31:0] model(input logic [7:0] s, input logic [31:0] x);
    logic [31:0] r;
    r = x;
    if (s == 8'd0) for (int i = 0; i < 32; i++) r[31-i] = x[i];
    else if (s == 8'd1) r = (x << 24) | ((x << 8) & 32'h00FF_0000) |
                            ((x >> 8) & 32'h0000_FF00) | (x >> 24);
    else if (s == 8'd2) r = (x << 16) | (x >> 16);
    return r;
  endfunction

  function automatic string req_of(input logic [7:0] s);
    if (s == 8'd0) return "R1";
    if (s == 8'd1) return "R2";
    if (s == 8'd2) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one request per call, no idle cycle afterwards
  task automatic issue(input logic [7:0] s, input logic [31:0] x);
    @(negedge clk);
    start = 1'b1; sel = s; operand = x; clk_en = 1'b1;
    exp_q.push_back(model(s, x));
    tag_q.push_back(req_of(s));
  endtask

  task automatic go_idle();
    @(negedge clk);
    start = 1'b0; sel = $urandom; operand = $urandom;
  endtask

  // monitor: pops expected words when done follows an enabled edge (R5)
  always @(posedge clk) begin
    logic en_s, rst_s;
    en_s = clk_en; rst_s = rst;
    #1;
    if (en_s && !rst_s && done) begin
      if (exp_q.size() == 0) check("R5 unexpected done", 32'(done), 32'd0);
      else check({tag_q.pop_front(), "/R5"}, result, exp_q.pop_front());
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; clk_en = 1'b0; start = 1'b0; sel = '0; operand = '0;
    repeat (3) @(negedge clk);
    check("R8 reset result", result, 32'd0);
    check("R8 reset done", 32'(done), 32'd0);
    rst = 1'b0; clk_en = 1'b1;

    // directed corner values
    issue(8'd0, 32'h0000_0001); issue(8'd0, 32'h1234_5678);
    issue(8'd1, 32'h1234_5678); issue(8'd2, 32'h1234_5678);
    issue(8'd3, 32'hDEAD_BEEF); issue(8'd255, 32'hCAFE_F00D);
    issue(8'd128, 32'hFFFF_0000);
    go_idle();
    @(negedge clk);

    // R6: idle cycles keep result and lower done
    held = result;
    repeat (3) begin
      @(posedge clk); #1;
      check("R6 idle done", 32'(done), 32'd0);
      check("R6 idle result", result, held);
    end

    // R7: stalled edge with start high changes nothing
    @(negedge clk);
    clk_en = 1'b0; start = 1'b1; sel = 8'd2; operand = 32'hA5A5_0F0F;
    @(posedge clk); #1;
    check("R7 stall done", 32'(done), 32'd0);
    check("R7 stall result", result, held);
    @(negedge clk);
    clk_en = 1'b1;
    exp_q.push_back(model(8'd2, 32'hA5A5_0F0F)); tag_q.push_back("R3");
    @(negedge clk);
    start = 1'b0;
    clk_en = 1'b0;
    held = result;
    repeat (2) begin
      @(posedge clk); #1;
      check("R7 stall hold done", 32'(done), 32'd1);
      check("R7 stall hold result", result, held);
    end
    @(negedge clk); clk_en = 1'b1;

    // random back-to-back traffic over all codes
    for (int i = 0; i < 600; i++) begin
      logic [7:0] s;
      s = (i % 4 == 3) ? 8'($urandom_range(3, 255)) : 8'(i % 4);
      issue(s, $urandom);
      if (i % 7 == 0) go_idle();
    end
    go_idle();
    repeat (3) @(negedge clk);
    check("R5 queue drained", 32'(exp_q.size()), 32'd0);

    // R8: reset while disabled clears a nonzero result
    issue(8'd4, 32'h8000_0001);
    go_idle();
    @(negedge clk);
    rst = 1'b1; clk_en = 1'b0;
    @(posedge clk); #1;
    check("R8 mid reset result", result, 32'd0);
    check("R8 mid reset done", 32'(done), 32'd0);
    @(negedge clk); rst = 1'b0; clk_en = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule